// File: doc/BRIEF.md
# Multi-Port Arbitrated Shared Memory

This block places one single-ported memory array behind several processor ports. Each port can raise a read or write request in any cycle. A single arbiter admits exactly one of them per clock. The winning access is carried out at the clock edge. A read answers one cycle later on a shared data bus, qualified by a valid strobe that is raised only on the port that won.

Each port also owns an address generator with three settings: a start address, a stride and an access count. When a port sets its generator-select input, the generator supplies the address instead of the port's own address input. The generated address moves forward by the stride after every access that port is granted. After the configured number of accesses it returns to the start. This lets a processor stream through a strided buffer without computing addresses itself.

A port that loses arbitration sees its stall bit raised and must hold its request, and its generated address stays put. Writes to a generator's settings are held back while that port has a request raised, and land in the first cycle when it has none. A global mode bit chooses between fixed priority (the lowest-numbered port wins) and round-robin. With the default parameters the model is 1024 words of 16 bits; setting the address width to 13 gives the full 16 KB array of 8192 words.

Top module: `shmem_arb_top`

## Requirements
- R1: In each cycle at most one port is granted, only a requesting port is granted, and a request is always granted when any port requests. Every requesting port that is not granted has its bit of `stall_o` high in that same cycle, and all other `stall_o` bits are low.
- R2: With the mode bit at 0, the requesting port with the lowest index is granted. The mode bit is 0 after reset.
- R3: A configuration write with `cfg_sel_i` = 3 sets the mode bit from bit 0 of `cfg_data_i`; `cfg_port_i` is ignored for this write. With the mode bit at 1, the search starts at the port after the most recently granted one and wraps around, so contending ports are served in rotation. Port 0 is searched first after reset.
- R4: A granted write stores its data at the access address at the clock edge. A granted read drives the stored word on `rdata_o` in the next cycle, with `rvalid_o` high only for the granted port. `rvalid_o` is low for writes and idle cycles.
- R5: With its `use_gen_i` bit at 0, a port accesses the address on its own field of `addr_i` (bits p*ADDR_W upward), and its generator is left unchanged.
- R6: With its `use_gen_i` bit at 1, a port accesses its generator's current address. After each granted access of that kind, the current address advances by the stride, modulo 2^ADDR_W.
- R7: A generator counts the granted accesses since it was last set to start. When that number reaches the count setting, the current address returns to the start and the counting begins again. A count of 0 or 1 keeps the address at the start.
- R8: A port that requests but is not granted keeps the same generated address into the next cycle.
- R9: A configuration write with `cfg_sel_i` of 0 (start), 1 (stride) or 2 (count) goes to the port selected by `cfg_port_i`. While that port's request is high, the write is held, and a later write to the same setting replaces the held one. In the first clock edge when the port's request is low, all held and current writes take effect, and the current address is set to the (new) start with the access count cleared.
- R10: After reset, no port is granted in an idle cycle, `rvalid_o` is 0, and every generator has start 0, stride 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_PORTS | Per-port access request |
| we_i | input | N_PORTS | Per-port write enable (1 write, 0 read) |
| use_gen_i | input | N_PORTS | Per-port select of the generated address |
| addr_i | input | N_PORTS*ADDR_W | Per-port direct addresses, port p at bits p*ADDR_W upward |
| wdata_i | input | N_PORTS*DATA_W | Per-port write data, port p at bits p*DATA_W upward |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_port_i | input | PORT_W | Port whose generator is configured |
| cfg_sel_i | input | 2 | Setting: 0 start, 1 stride, 2 count, 3 mode bit |
| cfg_data_i | input | ADDR_W | Configuration value |
| stall_o | output | N_PORTS | Per-port stall: requesting but not granted |
| rvalid_o | output | N_PORTS | Per-port read-data valid, one cycle after grant |
| rdata_o | output | DATA_W | Shared read data |

## Verification
The bench fills the whole array through direct writes. It then streams through a generator with a count of four and reads back where each word landed. A generator whose wrap came one access early or late would place data at the wrong addresses. A generator that advanced while stalled would make the stalled port read the wrong word once it is finally served. A configuration write is issued while the target port is stalled. The next grant must still use the old start and only the following one the new start, so a design that applied the setting at once would return the wrong word. A long random phase mixes mode switches, contention and configuration traffic against a behavioural model. A round-robin pointer that skipped or repeated a port, or a valid strobe raised on the wrong port or for a write, would show up there.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    // Configuration setting selector
    typedef enum logic [1:0] {
        CFG_BASE   = 2'd0,
        CFG_STRIDE = 2'd1,
        CFG_COUNT  = 2'd2,
        CFG_MODE   = 2'd3
    } cfg_field_e;

    localparam int N_GEN_FIELDS = 3;

    // One access as seen by the memory array
    typedef struct packed {
        logic en;
        logic we;
    } acc_ctl_t;

endpackage

// File: rtl/shmem_arbiter.sv
module shmem_arbiter #(
    parameter int N_PORTS = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [N_PORTS-1:0]                req,
    input  logic                              rr_en,
    output logic [N_PORTS-1:0]                gnt,
    output logic [$clog2(N_PORTS)-1:0]        gnt_idx
);
    localparam int PW = $clog2(N_PORTS);

    logic [PW-1:0] last_q;
    logic          found;
    logic [PW-1:0] cand;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        cand  = '0;
        for (int k = 0; k < N_PORTS; k++) begin
            if (rr_en) cand = PW'((int'(last_q) + 1 + k) % N_PORTS);
            else       cand = PW'(k);
            if (!found && req[cand]) begin
                gnt[cand] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (gnt[i]) gnt_idx = PW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last_q <= PW'(N_PORTS - 1);
        else if (|gnt) last_q <= gnt_idx;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R1
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R1
    AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt)); // R1
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (!rr_en && req[0]) |-> gnt[0]); // R2
    AST_RR_MOVES_ON: assert property (@(posedge clk) disable iff (rst)
        (rr_en && $countones(req) > 1) |-> !gnt[last_q]); // R3

endmodule

// File: rtl/shmem_addr_gen.sv
module shmem_addr_gen
    import shmem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              busy,
    input  logic              cfg_hit,
    input  cfg_field_e        cfg_field,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] base_q, stride_q, len_q, cur_q, idx_q;
    logic [N_GEN_FIELDS-1:0]             sh_v;
    logic [N_GEN_FIELDS-1:0][ADDR_W-1:0] sh_d;

    logic [N_GEN_FIELDS-1:0]             take, pick;
    logic [N_GEN_FIELDS-1:0][ADDR_W-1:0] val;
    logic                                apply, last_hit;
    logic [ADDR_W-1:0]                   nb, ns, nl;

    always_comb begin
        for (int f = 0; f < N_GEN_FIELDS; f++) begin
            take[f] = cfg_hit && (cfg_field == cfg_field_e'(2'(f)));
            val[f]  = take[f] ? cfg_data : sh_d[f];
            pick[f] = take[f] | sh_v[f];
        end
        apply = !busy && (|pick);
        nb = pick[CFG_BASE]   ? val[CFG_BASE]   : base_q;
        ns = pick[CFG_STRIDE] ? val[CFG_STRIDE] : stride_q;
        nl = pick[CFG_COUNT]  ? val[CFG_COUNT]  : len_q;
    end

    assign last_hit = ({1'b0, idx_q} + {{ADDR_W{1'b0}}, 1'b1}) >= {1'b0, len_q};
    assign cur_addr = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            stride_q <= '0;
            len_q    <= '0;
            cur_q    <= '0;
            idx_q    <= '0;
            sh_v     <= '0;
            sh_d     <= '0;
        end else if (apply) begin
            base_q   <= nb;
            stride_q <= ns;
            len_q    <= nl;
            cur_q    <= nb;
            idx_q    <= '0;
            sh_v     <= '0;
        end else begin
            if (step) begin
                if (last_hit) begin
                    cur_q <= base_q;
                    idx_q <= '0;
                end else begin
                    cur_q <= cur_q + stride_q;
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (busy) begin
                for (int f = 0; f < N_GEN_FIELDS; f++) begin
                    if (take[f]) begin
                        sh_v[f] <= 1'b1;
                        sh_d[f] <= cfg_data;
                    end
                end
            end
        end
    end

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
        (busy && !step) |=> $stable(cur_q)); // R8
    AST_CFG_DEFERRED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(base_q) && $stable(len_q)); // R9
    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (step && last_hit) |=> cur_q == $past(base_q)); // R7

endmodule

// File: rtl/shmem_array.sv
module shmem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end

endmodule

// File: rtl/shmem_arb_top.sv
module shmem_arb_top
    import shmem_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    localparam int PORT_W = $clog2(N_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_PORTS-1:0]          req_i,
    input  logic [N_PORTS-1:0]          we_i,
    input  logic [N_PORTS-1:0]          use_gen_i,
    input  logic [N_PORTS*ADDR_W-1:0]   addr_i,
    input  logic [N_PORTS*DATA_W-1:0]   wdata_i,
    input  logic                        cfg_we_i,
    input  logic [PORT_W-1:0]           cfg_port_i,
    input  logic [1:0]                  cfg_sel_i,
    input  logic [ADDR_W-1:0]           cfg_data_i,
    output logic [N_PORTS-1:0]          stall_o,
    output logic [N_PORTS-1:0]          rvalid_o,
    output logic [DATA_W-1:0]           rdata_o
);
    cfg_field_e         cfg_field;
    logic               rr_q;
    logic [N_PORTS-1:0] gnt;
    logic [PORT_W-1:0]  gidx;
    logic [N_PORTS-1:0] rvalid_q;
    logic [N_PORTS-1:0][ADDR_W-1:0] port_addr;
    logic [N_PORTS-1:0][ADDR_W-1:0] gen_addr;
    acc_ctl_t           acc;
    logic [ADDR_W-1:0]  acc_addr;
    logic [DATA_W-1:0]  acc_wdata;

    assign cfg_field = cfg_field_e'(cfg_sel_i);

    always_ff @(posedge clk) begin
        if (rst)                                  rr_q <= 1'b0;
        else if (cfg_we_i && cfg_field == CFG_MODE) rr_q <= cfg_data_i[0];
    end

    shmem_arbiter #(.N_PORTS(N_PORTS)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_i),
        .rr_en   (rr_q),
        .gnt     (gnt),
        .gnt_idx (gidx)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic hit;
        assign hit = cfg_we_i && (cfg_port_i == PORT_W'(p)) && (cfg_field != CFG_MODE);

        shmem_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
            .clk       (clk),
            .rst       (rst),
            .step      (gnt[p] & use_gen_i[p]),
            .busy      (req_i[p]),
            .cfg_hit   (hit),
            .cfg_field (cfg_field),
            .cfg_data  (cfg_data_i),
            .cur_addr  (gen_addr[p])
        );

        assign port_addr[p] = use_gen_i[p] ? gen_addr[p] : addr_i[p*ADDR_W +: ADDR_W];
    end

    assign acc.en    = |gnt;
    assign acc.we    = we_i[gidx];
    assign acc_addr  = port_addr[gidx];
    assign acc_wdata = wdata_i[gidx*DATA_W +: DATA_W];

    shmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .en    (acc.en),
        .we    (acc.we),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .rdata (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) rvalid_q <= '0;
        else     rvalid_q <= gnt & ~we_i;
    end

    assign rvalid_o = rvalid_q;
    assign stall_o  = req_i & ~gnt;

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rvalid_o)); // R4
    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (|rvalid_o) |-> $past(|(gnt & ~we_i))); // R4
    AST_STALL_HAS_WINNER: assert property (@(posedge clk) disable iff (rst)
        (|stall_o) |-> (|gnt)); // R1

endmodule

// File: tb/tb_shmem_arb_top.sv
module tb_shmem_arb_top;
    localparam int NP = 4;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic [NP-1:0]    req, we, use_gen;
    logic [NP*AW-1:0] addr;
    logic [NP*DW-1:0] wdata;
    logic             cfg_we;
    logic [1:0]       cfg_port, cfg_sel;
    logic [AW-1:0]    cfg_data;
    logic [NP-1:0]    stall, rvalid;
    logic [DW-1:0]    rdata;

    shmem_arb_top #(.N_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .req_i(req), .we_i(we), .use_gen_i(use_gen),
        .addr_i(addr), .wdata_i(wdata), .cfg_we_i(cfg_we), .cfg_port_i(cfg_port),
        .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .stall_o(stall),
        .rvalid_o(rvalid), .rdata_o(rdata)
    );

    int    n_run = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R10";

    // behavioural reference state
    int mbase[NP], mstep[NP], mlen[NP], mcur[NP], midx[NP];
    bit shv[NP][3];
    int shd[NP][3];
    bit mrr = 0;
    int mlast = NP - 1;
    logic [DW-1:0] mm [int];

    task automatic chk(bit ok, string t, string what, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    function automatic int pick();
        for (int k = 0; k < NP; k++) begin
            int c;
            c = mrr ? (mlast + 1 + k) % NP : k;
            if (req[c]) return c;
        end
        return -1;
    endfunction

    task automatic cycle();
        int g, a;
        logic [NP-1:0] est, erv;
        bit known;
        logic [DW-1:0] erd;
        #1;
        g = pick();
        est = req;
        if (g >= 0) est[g] = 1'b0;
        chk(stall == est, {tag, " R1"}, "stall", stall, est);
        erv = '0; known = 0; erd = '0;
        if (g >= 0) begin
            a = use_gen[g] ? mcur[g] : int'(addr[g*AW +: AW]);
            if (we[g]) mm[a] = wdata[g*DW +: DW];
            else begin
                erv[g] = 1'b1;
                if (mm.exists(a)) begin known = 1; erd = mm[a]; end
            end
            if (use_gen[g]) begin
                if (midx[g] + 1 >= mlen[g]) begin midx[g] = 0; mcur[g] = mbase[g]; end
                else begin midx[g]++; mcur[g] = (mcur[g] + mstep[g]) & MASK; end
            end
            mlast = g;
        end
        for (int p = 0; p < NP; p++) begin
            bit any;
            int v[3];
            any = 0;
            for (int f = 0; f < 3; f++) begin
                bit hit;
                hit = cfg_we && int'(cfg_port) == p && int'(cfg_sel) == f;
                if (!req[p]) begin
                    if (hit) begin v[f] = int'(cfg_data); any = 1; end
                    else if (shv[p][f]) begin v[f] = shd[p][f]; any = 1; end
                    else v[f] = (f == 0) ? mbase[p] : (f == 1) ? mstep[p] : mlen[p];
                end else if (hit) begin
                    shv[p][f] = 1; shd[p][f] = int'(cfg_data);
                end
            end
            if (any) begin
                mbase[p] = v[0]; mstep[p] = v[1]; mlen[p] = v[2];
                mcur[p] = v[0]; midx[p] = 0;
                for (int f = 0; f < 3; f++) shv[p][f] = 0;
            end
        end
        if (cfg_we && cfg_sel == 2'd3) mrr = cfg_data[0];
        @(posedge clk);
        @(negedge clk);
        chk(rvalid == erv, {tag, " R4"}, "rvalid", rvalid, erv);
        if (known) chk(rdata == erd, {tag, " R4"}, "rdata", rdata, erd);
    endtask

    task automatic idle();
        req = '0; we = '0; use_gen = '0; addr = '0; wdata = '0;
        cfg_we = 0; cfg_port = '0; cfg_sel = '0; cfg_data = '0;
    endtask

    task automatic setp(int p, bit r, bit w, bit g, int a, int d);
        req[p] = r; we[p] = w; use_gen[p] = g;
        addr[p*AW +: AW] = AW'(a);
        wdata[p*DW +: DW] = DW'(d);
    endtask

    task automatic cfg(int p, int s, int d);
        cfg_we = 1; cfg_port = 2'(p); cfg_sel = 2'(s); cfg_data = AW'(d);
        cycle();
        cfg_we = 0;
    endtask

    function automatic logic [DW-1:0] pf(int a);
        return DW'(a) ^ 16'h5A5A;
    endfunction

    initial begin
        for (int p = 0; p < NP; p++) begin
            mbase[p] = 0; mstep[p] = 0; mlen[p] = 0; mcur[p] = 0; midx[p] = 0;
            for (int f = 0; f < 3; f++) begin shv[p][f] = 0; shd[p][f] = 0; end
        end
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(rvalid == '0, "R10", "rvalid after reset", rvalid, 0);
        chk(stall == '0, "R10", "stall after reset", stall, 0);
        cycle();

        // direct-address fill of the whole array
        tag = "R5";
        for (int a = 0; a <= MASK; a++) begin
            idle(); setp(0, 1, 1, 0, a, pf(a)); cycle();
        end
        idle(); setp(1, 1, 0, 0, 77, 0); cycle();
        chk(rdata == pf(77), "R5", "direct read", rdata, pf(77));

        // reset generator of port 0 sits at address 0
        tag = "R10";
        idle(); setp(0, 1, 0, 1, 500, 0); cycle();
        chk(rdata == pf(0), "R10", "generator reset address", rdata, pf(0));

        // fixed priority with all four requesting
        tag = "R2";
        idle();
        for (int p = 0; p < NP; p++) setp(p, 1, 0, 0, p + 10, 0);
        cycle();
        chk(rvalid == 4'b0001, "R2", "lowest index wins", rvalid, 4'b0001);
        chk(rdata == pf(10), "R2", "winner data", rdata, pf(10));

        // generator stream with stride 3, count 4
        tag = "R6";
        idle();
        cfg(2, 0, 16); cfg(2, 1, 3); cfg(2, 2, 4);
        for (int k = 0; k < 6; k++) begin
            idle(); setp(2, 1, 1, 1, 0, 16'hA000 + k); cycle();
        end
        idle(); setp(3, 1, 0, 0, 22, 0); cycle();
        chk(rdata == 16'hA002, "R6", "strided address 22", rdata, 16'hA002);
        idle(); setp(3, 1, 0, 0, 25, 0); cycle();
        chk(rdata == 16'hA003, "R6", "strided address 25", rdata, 16'hA003);
        tag = "R7";
        idle(); setp(3, 1, 0, 0, 16, 0); cycle();
        chk(rdata == 16'hA004, "R7", "wrap rewrote start", rdata, 16'hA004);

        // stalled generator keeps its address
        tag = "R8";
        idle(); setp(0, 1, 0, 0, 3, 0); setp(2, 1, 0, 1, 0, 0); cycle();
        chk(rvalid == 4'b0001, "R8", "port 2 stalled", rvalid, 4'b0001);
        idle(); setp(2, 1, 0, 1, 0, 0); cycle();
        chk(rdata == 16'hA002, "R8", "address held over stall", rdata, 16'hA002);

        // count 1 stays at start
        tag = "R7";
        idle(); cfg(3, 0, 100); cfg(3, 1, 5); cfg(3, 2, 1);
        for (int k = 0; k < 2; k++) begin
            idle(); setp(3, 1, 0, 1, 0, 0); cycle();
            chk(rdata == pf(100), "R7", "count 1 holds start", rdata, pf(100));
        end

        // deferred configuration
        tag = "R9";
        idle(); setp(0, 1, 0, 0, 7, 0); setp(1, 1, 0, 1, 0, 0);
        cfg(1, 0, 40);
        idle(); setp(1, 1, 0, 1, 0, 0); cycle();
        chk(rdata == pf(0), "R9", "old start while pending", rdata, pf(0));
        idle(); cycle();
        idle(); setp(1, 1, 0, 1, 0, 0); cycle();
        chk(rdata == pf(40), "R9", "new start after release", rdata, pf(40));

        // round-robin rotation
        tag = "R3";
        begin
            logic [NP-1:0] seen;
            idle(); cfg(2, 3, 1);
            seen = '0;
            for (int k = 0; k < NP; k++) begin
                idle();
                for (int p = 0; p < NP; p++) setp(p, 1, 0, 0, p, 0);
                cycle();
                seen |= rvalid;
            end
            chk(seen == 4'hF, "R3", "every port served in rotation", seen, 4'hF);
        end

        // random traffic against the model
        tag = "R1 R2 R3 R6 R7 R8 R9 random";
        for (int n = 0; n < 3000; n++) begin
            idle();
            for (int p = 0; p < NP; p++)
                setp(p, $urandom_range(0, 99) < 45, $urandom_range(0, 2) == 0,
                     $urandom_range(0, 1) == 1, $urandom_range(0, MASK),
                     $urandom_range(0, 16'hFFFF));
            if ($urandom_range(0, 9) == 0) begin
                cfg_we = 1; cfg_port = 2'($urandom_range(0, 3));
                cfg_sel = 2'($urandom_range(0, 3));
                cfg_data = AW'($urandom_range(0, 7) == 0 ? $urandom_range(0, 1)
                                                         : $urandom_range(0, 9));
            end
            cycle();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule